// File: doc/BRIEF.md
# Prefix Hash Generator

This block turns a multi-byte key into a set of independent universal hash values. Every hash is built by AND-XOR reduction. Each key bit gates a constant word that belongs to that bit and to that hash. The gated words are then XORed together. The block walks the key one bit at a time, so the result after bit j is also the hash of the key's first j bits. Because of this, one XOR chain per hash function gives the hash of every whole-byte prefix, from a minimum byte count up to the full key. A stage that checks substrings of several lengths can take all of its hashes from one unit.

The constant words are reset to a pseudo-random sequence derived from a seed parameter. A write port can overwrite any single word, one word per cycle. An optional output register, chosen by a parameter, adds one cycle of latency. Its valid flag travels with the data.

Top module: `prefix_hash_gen`

## Requirements
- R1: Key bit j is `key_i[j]`, and byte 0 is `key_i[7:0]`. Hash h over the full key is the XOR of the words at constant index `h*KEY_BYTES*8 + j`, taken for every j where bit j is 1.
- R2: The prefix output for n bytes (MIN_BYTES <= n <= KEY_BYTES) depends only on key bits 0 to 8n-1. It sits in `prefix_hash_o` at slot `(n-MIN_BYTES)*NUM_HASH + h`, and each slot is HASH_W bits wide, with slot 0 in the low bits.
- R3: An all-zero key yields zero on every hash of every prefix.
- R4: After reset, constant index i holds the low HASH_W bits of a 32-bit register after i+1 steps. The register starts from SEED (1 if SEED is 0). One step is `s = (s >> 1) ^ (s[0] ? 32'hB4BCD35C : 0)`. Taking the low bits is the same as reduction modulo m = 2^HASH_W.
- R5: A write with `ld_en_i` high replaces the constant at `ld_addr_i` with `ld_word_i` at the clock edge. A key presented in the same cycle is hashed with the old word, and a key presented in a later cycle uses the new one.
- R6: With LATENCY = 1, the outputs for a key accepted at one edge appear after that edge. `out_valid_o` is high exactly one cycle after each cycle in which `key_valid_i` is high, and it is low during and just after reset.
- R7: With LATENCY = 1, `prefix_hash_o` holds its value in every cycle that follows one with `key_valid_i` low, even while constants are being written.
- R8: A write to an address at or above `NUM_HASH*KEY_BYTES*8` changes no constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| key_valid_i | input | 1 | Key present this cycle |
| key_i | input | KEY_BYTES*8 | Key, byte 0 in the low bits |
| ld_en_i | input | 1 | Constant write strobe |
| ld_addr_i | input | $clog2(NUM_HASH*KEY_BYTES*8+1) | Constant index to write |
| ld_word_i | input | HASH_W | New constant word |
| out_valid_o | output | 1 | Hash results valid |
| prefix_hash_o | output | (KEY_BYTES-MIN_BYTES+1)*NUM_HASH*HASH_W | All prefix hashes, packed by prefix, then by hash |

## Verification
A constant write and a key lookup can fall in the same cycle, and the design must then hash the key with the word as it was before the edge. The bench drives a key that sets bit 0 and, in the same cycle, writes hash 0's bit-0 constant. It expects the old word in the result and then expects the new word from the next key. A second overlap is a constant write during idle cycles, where the registered outputs must not move.

// File: rtl/hg_pkg.sv
package hg_pkg;

    localparam logic [31:0] LFSR_TAPS = 32'hB4BCD35C;

    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? LFSR_TAPS : 32'h0);
    endfunction

    // state after idx+1 steps from the seed (zero seed replaced by 1)
    function automatic logic [31:0] seed_word(input logic [31:0] seed, input int idx);
        logic [31:0] s;
        s = (seed == 32'h0) ? 32'h1 : seed;
        for (int n = 0; n <= idx; n++) s = lfsr_step(s);
        return s;
    endfunction

endpackage

// File: rtl/hg_const_bank.sv
module hg_const_bank #(
    parameter int          NUM_WORDS = 128,
    parameter int          WORD_W    = 12,
    parameter logic [31:0] SEED      = 32'h1D2C3B4A,
    localparam int         ADDR_W    = $clog2(NUM_WORDS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ld_en_i,
    input  logic [ADDR_W-1:0]           ld_addr_i,
    input  logic [WORD_W-1:0]           ld_word_i,
    output logic [NUM_WORDS*WORD_W-1:0] words_o
);

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam logic [31:0]       INIT_FULL = hg_pkg::seed_word(SEED, i);
        localparam logic [WORD_W-1:0] INIT      = INIT_FULL[WORD_W-1:0];
        logic [WORD_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= INIT;
            end else if (ld_en_i && (ld_addr_i == ADDR_W'(i))) begin
                word_q <= ld_word_i;
            end
        end

        assign words_o[i*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/hg_xor_chain.sv
module hg_xor_chain #(
    parameter int  KEY_BYTES = 4,
    parameter int  MIN_BYTES = 2,
    parameter int  WORD_W    = 12,
    localparam int KEY_W     = KEY_BYTES * 8,
    localparam int NUM_PFX   = KEY_BYTES - MIN_BYTES + 1
) (
    input  logic [KEY_W-1:0]          key_i,
    input  logic [KEY_W*WORD_W-1:0]   consts_i,
    output logic [NUM_PFX*WORD_W-1:0] pfx_o
);

    logic [WORD_W-1:0] acc [KEY_W+1];

    assign acc[0] = '0;

    // each step extends the previous partial hash by one key bit
    for (genvar j = 0; j < KEY_W; j++) begin : g_step
        assign acc[j+1] = acc[j] ^ (consts_i[j*WORD_W +: WORD_W] & {WORD_W{key_i[j]}});
    end

    for (genvar p = 0; p < NUM_PFX; p++) begin : g_tap
        assign pfx_o[p*WORD_W +: WORD_W] = acc[(MIN_BYTES + p) * 8];
    end

endmodule

// File: rtl/hg_out_stage.sv
module hg_out_stage #(
    parameter int DATA_W  = 144,
    parameter int LATENCY = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);

    if (LATENCY == 0) begin : g_comb
        assign valid_o = valid_i;
        assign data_o  = data_i;
    end else begin : g_reg
        logic              valid_q;
        logic [DATA_W-1:0] data_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                data_q  <= '0;
            end else begin
                valid_q <= valid_i;
                if (valid_i) data_q <= data_i;
            end
        end

        assign valid_o = valid_q;
        assign data_o  = data_q;
    end

endmodule

// File: rtl/prefix_hash_gen.sv
module prefix_hash_gen #(
    parameter int          KEY_BYTES = 4,
    parameter int          MIN_BYTES = 2,
    parameter int          NUM_HASH  = 4,
    parameter int          HASH_W    = 12,
    parameter logic [31:0] SEED      = 32'h1D2C3B4A,
    parameter int          LATENCY   = 1,
    localparam int         KEY_W     = KEY_BYTES * 8,
    localparam int         NUM_WORDS = NUM_HASH * KEY_W,
    localparam int         ADDR_W    = $clog2(NUM_WORDS + 1),
    localparam int         NUM_PFX   = KEY_BYTES - MIN_BYTES + 1,
    localparam int         OUT_W     = NUM_PFX * NUM_HASH * HASH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic              ld_en_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [HASH_W-1:0] ld_word_i,
    output logic              out_valid_o,
    output logic [OUT_W-1:0]  prefix_hash_o
);

    logic [NUM_WORDS*HASH_W-1:0] words;
    logic [OUT_W-1:0]            hash_comb;

    hg_const_bank #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (HASH_W),
        .SEED      (SEED)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en_i   (ld_en_i),
        .ld_addr_i (ld_addr_i),
        .ld_word_i (ld_word_i),
        .words_o   (words)
    );

    for (genvar h = 0; h < NUM_HASH; h++) begin : g_hash
        logic [NUM_PFX*HASH_W-1:0] pfx;

        hg_xor_chain #(
            .KEY_BYTES (KEY_BYTES),
            .MIN_BYTES (MIN_BYTES),
            .WORD_W    (HASH_W)
        ) u_chain (
            .key_i    (key_i),
            .consts_i (words[h*KEY_W*HASH_W +: KEY_W*HASH_W]),
            .pfx_o    (pfx)
        );

        // regroup: prefix-major, hash-minor
        for (genvar p = 0; p < NUM_PFX; p++) begin : g_slot
            assign hash_comb[(p*NUM_HASH + h)*HASH_W +: HASH_W] = pfx[p*HASH_W +: HASH_W];
        end
    end

    hg_out_stage #(
        .DATA_W  (OUT_W),
        .LATENCY (LATENCY)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (key_valid_i),
        .data_i  (hash_comb),
        .valid_o (out_valid_o),
        .data_o  (prefix_hash_o)
    );

endmodule

// File: rtl/prefix_hash_gen_chk.sv
module prefix_hash_gen_chk #(
    parameter int  KEY_BYTES = 4,
    parameter int  MIN_BYTES = 2,
    parameter int  NUM_HASH  = 4,
    parameter int  HASH_W    = 12,
    parameter int  LATENCY   = 1,
    localparam int KEY_W     = KEY_BYTES * 8,
    localparam int NUM_PFX   = KEY_BYTES - MIN_BYTES + 1,
    localparam int GRP_W     = NUM_HASH * HASH_W,
    localparam int OUT_W     = NUM_PFX * GRP_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             key_valid_i,
    input logic [KEY_W-1:0] key_i,
    input logic             out_valid_o,
    input logic [OUT_W-1:0] prefix_hash_o
);

    logic upper_zero;
    logic pfx_all_eq;

    assign upper_zero = ((key_i >> (MIN_BYTES * 8)) == '0);

    always_comb begin
        pfx_all_eq = 1'b1;
        for (int p = 1; p < NUM_PFX; p++) begin
            if (prefix_hash_o[p*GRP_W +: GRP_W] != prefix_hash_o[0 +: GRP_W]) pfx_all_eq = 1'b0;
        end
    end

    if (LATENCY == 1) begin : g_lat1
        p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            key_valid_i |=> out_valid_o);
        p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !key_valid_i |=> !out_valid_o);
        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !key_valid_i |=> $stable(prefix_hash_o));
        p_zero_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (key_valid_i && key_i == '0) |=> (prefix_hash_o == '0));
        p_prefix_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (key_valid_i && upper_zero) |=> pfx_all_eq);
    end else begin : g_lat0
        p_zero_key_comb_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (key_valid_i && key_i == '0) |-> (prefix_hash_o == '0));
        p_prefix_ext_comb_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (key_valid_i && upper_zero) |-> pfx_all_eq);
        p_valid_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
            key_valid_i |-> out_valid_o);
        p_valid_pass_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !key_valid_i |-> !out_valid_o);
    end

endmodule

bind prefix_hash_gen prefix_hash_gen_chk #(
    .KEY_BYTES (KEY_BYTES),
    .MIN_BYTES (MIN_BYTES),
    .NUM_HASH  (NUM_HASH),
    .HASH_W    (HASH_W),
    .LATENCY   (LATENCY)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .key_valid_i   (key_valid_i),
    .key_i         (key_i),
    .out_valid_o   (out_valid_o),
    .prefix_hash_o (prefix_hash_o)
);

// File: tb/test_prefix_hash_gen.sv
module test_prefix_hash_gen;

    localparam int          KB    = 4;
    localparam int          MINB  = 2;
    localparam int          NH    = 4;
    localparam int          HW    = 12;
    localparam logic [31:0] SEED  = 32'h1D2C3B4A;
    localparam int          KW    = KB * 8;
    localparam int          NW    = NH * KW;
    localparam int          AW    = $clog2(NW + 1);
    localparam int          NP    = KB - MINB + 1;
    localparam int          GW    = NH * HW;
    localparam int          OW    = NP * GW;
    localparam int          NVEC  = 8;

    localparam logic [KW-1:0] KEYS [NVEC] = '{
        32'h00000001, 32'h80000000, 32'hFFFFFFFF, 32'h12345678,
        32'hA5A5A5A5, 32'h0000FF00, 32'hDEADBEEF, 32'h00010000
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_valid_i = 1'b0;
    logic [KW-1:0] key_i = '0;
    logic          ld_en_i = 1'b0;
    logic [AW-1:0] ld_addr_i = '0;
    logic [HW-1:0] ld_word_i = '0;
    logic          out_valid_o;
    logic [OW-1:0] prefix_hash_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [HW-1:0] cst [NW];

    always #2 clk = ~clk;

    prefix_hash_gen #(
        .KEY_BYTES (KB), .MIN_BYTES (MINB), .NUM_HASH (NH),
        .HASH_W (HW), .SEED (SEED), .LATENCY (1)
    ) i_prefix_hash_gen (
        .clk (clk), .rst_n (rst_n), .key_valid_i (key_valid_i), .key_i (key_i),
        .ld_en_i (ld_en_i), .ld_addr_i (ld_addr_i), .ld_word_i (ld_word_i),
        .out_valid_o (out_valid_o), .prefix_hash_o (prefix_hash_o)
    );

    function automatic logic [HW-1:0] model_hash(input int h, input logic [KW-1:0] key, input int nbits);
        logic [HW-1:0] r = '0;
        for (int j = 0; j < nbits; j++) if (key[j]) r ^= cst[h*KW + j];
        return r;
    endfunction

    task automatic check(input string req, input logic [GW-1:0] act, input logic [GW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_const(input int addr, input logic [HW-1:0] w);
        @(negedge clk);
        ld_en_i = 1'b1; ld_addr_i = AW'(addr); ld_word_i = w;
        @(negedge clk);
        ld_en_i = 1'b0;
    endtask

    // drive one key, sample after the registering edge
    task automatic apply_key(input logic [KW-1:0] k, input string req);
        @(negedge clk);
        key_valid_i = 1'b1; key_i = k;
        @(negedge clk);
        key_valid_i = 1'b0;
        check({req, " valid"}, GW'(out_valid_o), GW'(1'b1));
        for (int p = 0; p < NP; p++) begin
            logic [GW-1:0] e;
            for (int h = 0; h < NH; h++) e[h*HW +: HW] = model_hash(h, k, (MINB + p) * 8);
            check(req, prefix_hash_o[p*GW +: GW], e);
        end
    endtask

    initial begin
        logic [31:0]   s;
        logic [OW-1:0] held;
        logic [HW-1:0] old0;

        // R4 reference sequence
        s = SEED;
        for (int i = 0; i < NW; i++) begin
            s = {1'b0, s[31:1]} ^ (s[0] ? 32'hB4BCD35C : 32'h0);
            cst[i] = s[HW-1:0];
        end

        repeat (3) @(negedge clk);
        check("R6 reset valid", GW'(out_valid_o), GW'(1'b0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 idle after reset", GW'(out_valid_o), GW'(1'b0));

        // R4 / R1 / R2: seeded constants
        for (int v = 0; v < NVEC; v++) apply_key(KEYS[v], "R4 R1 R2 seeded");

        // R5: load every word, then repeat the vector walk
        for (int i = 0; i < NW; i++) begin
            logic [HW-1:0] w = HW'(i * 32'h29B + 32'h51);
            write_const(i, w);
            cst[i] = w;
        end
        for (int v = 0; v < NVEC; v++) apply_key(KEYS[v], "R5 R1 R2 loaded");

        // R3: all-zero key
        apply_key('0, "R3 zero key");

        // R5: write and lookup in the same cycle
        old0 = cst[0];
        @(negedge clk);
        key_valid_i = 1'b1; key_i = 32'h1;
        ld_en_i = 1'b1; ld_addr_i = '0; ld_word_i = 12'hABC;
        @(negedge clk);
        key_valid_i = 1'b0; ld_en_i = 1'b0;
        check("R5 same-cycle old word", GW'(prefix_hash_o[HW-1:0]), GW'(old0));
        cst[0] = 12'hABC;
        apply_key(32'h1, "R5 new word next key");

        // R8: out-of-range write is dropped
        write_const(NW + 72, 12'h777);
        apply_key('1, "R8 out-of-range write");

        // R7: outputs hold while idle, even across a constant write
        held = prefix_hash_o;
        write_const(1, 12'h5A5);
        cst[1] = 12'h5A5;
        @(negedge clk);
        check("R7 hold", prefix_hash_o[GW-1:0], held[GW-1:0]);
        check("R7 hold top", prefix_hash_o[OW-1 -: GW], held[OW-1 -: GW]);
        check("R6 idle valid", GW'(out_valid_o), GW'(1'b0));
        apply_key(32'h2, "R1 after idle write");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule